// File: doc/BRIEF.md
# Dual-Slot Scoreboard Issue Unit

This block sits between a two-wide decode stage and the execution units of an out-of-order core. Each cycle it looks at up to two decoded instructions, an older one in slot 0 and a younger one in slot 1. For each one it decides whether that instruction may be sent to execution in this cycle. Every instruction names one destination register, two source registers and a latency class. The decision comes from a scoreboard that holds, for each architectural register, two counts: how many in-flight instructions read it and how many write it. An instruction is held back if it would read a register that is still being produced, or overwrite a register that an in-flight instruction still reads or writes.

Issued instructions travel down a short latency pipeline. When an instruction reaches the end of that pipeline, a retire strobe is raised for one cycle and the instruction's scoreboard counts are released. The upstream stage keeps an instruction in its slot until it sees that slot's issue strobe. A mode input selects between two policies. In strict in-order issue, a stalled older slot also holds the younger one. In out-of-order issue, an independent younger instruction may go ahead of a stalled older one.

Top module: `dis_issue_sb`

## Requirements
- R1: While reset is held and in the cycle after it is released, `retire` is 0 and every scoreboard count is zero, so the first valid instruction with no hazard issues at once.
- R2: A valid slot-0 instruction with no hazard raises `issue0` combinationally in the same cycle it is presented.
- R3: An instruction does not issue while either of its source registers has a pending writer (read-after-write).
- R4: An instruction does not issue while its destination register has a pending reader (write-after-read).
- R5: An instruction does not issue while its destination register has a pending writer (write-after-write).
- R6: An instruction issued in cycle t raises exactly one retire bit. For the add class (`mul`=0) that bit is high in cycle t+2; for the multiply class (`mul`=1) it is high in cycle t+3. The bit index is slot*2 + mul: bit 0 = slot 0 add, bit 1 = slot 0 multiply, bit 2 = slot 1 add, bit 3 = slot 1 multiply.
- R7: The counts an instruction holds are released at the end of its retire cycle. An instruction that waits on it can issue in the next cycle, and not in the retire cycle itself.
- R8: Whenever slot 0 is valid, slot 1 does not issue if it conflicts with slot 0's registers. A conflict is a slot-1 source equal to the slot-0 destination, or a slot-1 destination equal to a slot-0 source or to the slot-0 destination. This holds whether or not slot 0 issues.
- R9: With `ooo_en`=0, `issue1` stays low whenever slot 0 is valid and `issue0` is low.
- R10: With `ooo_en`=1, a hazard-free, non-conflicting slot-1 instruction issues even while slot 0 is valid and stalled.
- R11: Both slots can issue in one cycle, and both are recorded in the scoreboard.
- R12: An invalid slot never issues and never changes the scoreboard, whatever its register fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ooo_en | input | 1 | 1 = younger slot may bypass a stalled older slot |
| s0_valid | input | 1 | Slot 0 (older) holds an instruction |
| s0_dst | input | REG_W | Slot 0 destination register |
| s0_srca | input | REG_W | Slot 0 first source register |
| s0_srcb | input | REG_W | Slot 0 second source register |
| s0_mul | input | 1 | Slot 0 latency class, 1 = multiply (3 cycles) |
| s1_valid | input | 1 | Slot 1 (younger) holds an instruction |
| s1_dst | input | REG_W | Slot 1 destination register |
| s1_srca | input | REG_W | Slot 1 first source register |
| s1_srcb | input | REG_W | Slot 1 second source register |
| s1_mul | input | 1 | Slot 1 latency class, 1 = multiply (3 cycles) |
| issue0 | output | 1 | Slot 0 issues this cycle |
| issue1 | output | 1 | Slot 1 issues this cycle |
| retire | output | 4 | One-cycle retire strobes, index slot*2 + mul |

## Verification
The bench targets the release edge. A design that frees counts one cycle early lets a dependent instruction issue in its producer's retire cycle. A design that frees them late adds a dead cycle, and the cycle-exact reference model catches either. Dense random streams over only eight registers bring up same-register sources, an instruction that reads its own destination, and a slot pair that conflicts while slot 0 is stalled. A design that checks the pair only when slot 0 issues would let slot 1 overtake a register hazard. Each stream runs in both modes, so a missing in-order hold or a missing bypass shows up as a wrong `issue1`. Bubbles that carry random register fields in the invalid slots expose any count touched by an invalid slot. The back-to-back mix of multiply and add classes makes two retirements from the same slot land in one cycle, which a single shared retire pipeline would lose.

// File: rtl/dis_pkg.sv
// Shared sizes and the decoded-instruction record for the dual-slot issue unit.
// Assumes two issue slots and two latency classes (add, multiply).
package dis_pkg;
    parameter int NUM_REGS  = 8;
    parameter int REG_W     = $clog2(NUM_REGS);
    parameter int ADD_LAT   = 2;
    parameter int MUL_LAT   = 3;
    localparam int NUM_SLOTS = 2;
    localparam int NUM_LANES = NUM_SLOTS * 2;
    // worst case: every in-flight instruction reads the same register twice
    localparam int CNT_W     = $clog2(NUM_SLOTS * 2 * MUL_LAT + 1);

    typedef struct packed {
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] srca;
        logic [REG_W-1:0] srcb;
        logic             mul;
    } instr_t;
endpackage

// File: rtl/dis_hazard.sv
// Issue decision for two slots. Uses per-register busy flags from the
// scoreboard and compares the younger slot with a valid older slot.
// Assumes the upstream keeps an unissued instruction in its slot.
module dis_hazard
    import dis_pkg::*;
(
    input  logic                            ooo_en,
    input  logic [NUM_SLOTS-1:0]            slot_vld,
    input  instr_t [NUM_SLOTS-1:0]          slot_ins,
    input  logic [NUM_REGS-1:0]             rd_busy,
    input  logic [NUM_REGS-1:0]             wr_busy,
    output logic [NUM_SLOTS-1:0]            issue
);
    logic [NUM_SLOTS-1:0] hz;
    logic                 pair_conf;

    // scoreboard hazard per slot: RAW on sources, WAR and WAW on destination
    always_comb begin
        for (int s = 0; s < NUM_SLOTS; s++) begin
            hz[s] = wr_busy[slot_ins[s].srca] | wr_busy[slot_ins[s].srcb] |
                    rd_busy[slot_ins[s].dst]  | wr_busy[slot_ins[s].dst];
        end
    end

    // younger-versus-older register overlap, as if the older were recorded
    always_comb begin
        pair_conf = (slot_ins[1].srca == slot_ins[0].dst) ||
                    (slot_ins[1].srcb == slot_ins[0].dst) ||
                    (slot_ins[1].dst  == slot_ins[0].srca) ||
                    (slot_ins[1].dst  == slot_ins[0].srcb) ||
                    (slot_ins[1].dst  == slot_ins[0].dst);
    end

    // final issue strobes with the ordering policy applied
    always_comb begin
        issue[0] = slot_vld[0] && !hz[0];
        issue[1] = slot_vld[1] && !hz[1] && !(slot_vld[0] && pair_conf) &&
                   (ooo_en || !slot_vld[0] || issue[0]);
    end
endmodule

// File: rtl/dis_latpipe.sv
// Latency pipeline: one shift lane per (slot, class) pair so no two
// instructions ever compete for a stage. A lane's last stage is its retire.
module dis_latpipe
    import dis_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SLOTS-1:0]        iss_vld,
    input  instr_t [NUM_SLOTS-1:0]      iss_ins,
    output logic [NUM_LANES-1:0]        ret_vld,
    output instr_t [NUM_LANES-1:0]      ret_ins
);
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        localparam int   SL     = l / 2;
        localparam logic IS_MUL = logic'(l % 2);
        localparam int   DEPTH  = (l % 2 == 1) ? MUL_LAT : ADD_LAT;

        logic [DEPTH-1:0] v_q;
        instr_t           pl_q [DEPTH];
        logic             take;

        assign take = iss_vld[SL] && (iss_ins[SL].mul == IS_MUL);

        // valid bits shift toward retire; cleared by reset
        always_ff @(posedge clk) begin
            if (!rst_n) v_q <= '0;
            else        v_q <= {v_q[DEPTH-2:0], take};
        end

        // payload follows the valid bit; no reset needed
        always_ff @(posedge clk) begin
            pl_q[0] <= iss_ins[SL];
            for (int k = 1; k < DEPTH; k++) pl_q[k] <= pl_q[k-1];
        end

        assign ret_vld[l] = v_q[DEPTH-1];
        assign ret_ins[l] = pl_q[DEPTH-1];
    end
endmodule

// File: rtl/dis_counters.sv
// Scoreboard: a reader count and a writer count per register. Issues add,
// retirements subtract, both in the same edge. Exposes non-zero flags.
module dis_counters
    import dis_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SLOTS-1:0]        iss_vld,
    input  instr_t [NUM_SLOTS-1:0]      iss_ins,
    input  logic [NUM_LANES-1:0]        ret_vld,
    input  instr_t [NUM_LANES-1:0]      ret_ins,
    output logic [NUM_REGS-1:0]         rd_busy,
    output logic [NUM_REGS-1:0]         wr_busy
);
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        localparam logic [REG_W-1:0] RID = REG_W'(r);
        logic [CNT_W-1:0] rd_q, wr_q, rd_add, rd_sub, wr_add, wr_sub;

        // tally this register's increments and decrements
        always_comb begin
            rd_add = '0; wr_add = '0; rd_sub = '0; wr_sub = '0;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (iss_vld[s]) begin
                    if (iss_ins[s].srca == RID) rd_add = rd_add + CNT_W'(1);
                    if (iss_ins[s].srcb == RID) rd_add = rd_add + CNT_W'(1);
                    if (iss_ins[s].dst  == RID) wr_add = wr_add + CNT_W'(1);
                end
            end
            for (int l = 0; l < NUM_LANES; l++) begin
                if (ret_vld[l]) begin
                    if (ret_ins[l].srca == RID) rd_sub = rd_sub + CNT_W'(1);
                    if (ret_ins[l].srcb == RID) rd_sub = rd_sub + CNT_W'(1);
                    if (ret_ins[l].dst  == RID) wr_sub = wr_sub + CNT_W'(1);
                end
            end
        end

        // count registers
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_q <= '0;
                wr_q <= '0;
            end else begin
                rd_q <= rd_q + rd_add - rd_sub;
                wr_q <= wr_q + wr_add - wr_sub;
            end
        end

        assign rd_busy[r] = (rd_q != '0);
        assign wr_busy[r] = (wr_q != '0);
    end
endmodule

// File: rtl/dis_issue_sb.sv
// Top of the dual-slot scoreboard issue unit. Packs the slot ports into
// records and wires hazard check, scoreboard counts and latency pipeline.
// Counts of an instruction retiring this cycle still block this cycle.
module dis_issue_sb
    import dis_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ooo_en,
    input  logic                 s0_valid,
    input  logic [REG_W-1:0]     s0_dst,
    input  logic [REG_W-1:0]     s0_srca,
    input  logic [REG_W-1:0]     s0_srcb,
    input  logic                 s0_mul,
    input  logic                 s1_valid,
    input  logic [REG_W-1:0]     s1_dst,
    input  logic [REG_W-1:0]     s1_srca,
    input  logic [REG_W-1:0]     s1_srcb,
    input  logic                 s1_mul,
    output logic                 issue0,
    output logic                 issue1,
    output logic [NUM_LANES-1:0] retire
);
    logic [NUM_SLOTS-1:0]   slot_vld, iss;
    instr_t [NUM_SLOTS-1:0] slot_ins;
    instr_t [NUM_LANES-1:0] ret_ins;
    logic [NUM_REGS-1:0]    rd_busy, wr_busy;

    assign slot_vld = {s1_valid, s0_valid};
    assign slot_ins[0] = '{dst: s0_dst, srca: s0_srca, srcb: s0_srcb, mul: s0_mul};
    assign slot_ins[1] = '{dst: s1_dst, srca: s1_srca, srcb: s1_srcb, mul: s1_mul};

    dis_hazard u_hz (
        .ooo_en   (ooo_en),
        .slot_vld (slot_vld),
        .slot_ins (slot_ins),
        .rd_busy  (rd_busy),
        .wr_busy  (wr_busy),
        .issue    (iss)
    );

    dis_counters u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .iss_vld (iss),
        .iss_ins (slot_ins),
        .ret_vld (retire),
        .ret_ins (ret_ins),
        .rd_busy (rd_busy),
        .wr_busy (wr_busy)
    );

    dis_latpipe u_lp (
        .clk     (clk),
        .rst_n   (rst_n),
        .iss_vld (iss),
        .iss_ins (slot_ins),
        .ret_vld (retire),
        .ret_ins (ret_ins)
    );

    assign issue0 = iss[0];
    assign issue1 = iss[1];
endmodule

// File: rtl/dis_sb_chk.sv
// Port-level temporal checks for dis_issue_sb, attached by bind.
module dis_sb_chk
    import dis_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ooo_en,
    input logic                 s0_valid,
    input logic [REG_W-1:0]     s0_dst,
    input logic                 s0_mul,
    input logic                 s1_valid,
    input logic [REG_W-1:0]     s1_dst,
    input logic [REG_W-1:0]     s1_srca,
    input logic                 s1_mul,
    input logic                 issue0,
    input logic                 issue1,
    input logic [NUM_LANES-1:0] retire
);
    // R12
    invalid_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s0_valid |-> !issue0) and (!s1_valid |-> !issue1));
    // R9
    inorder_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ooo_en && s0_valid && !issue0) |-> !issue1);
    // R6
    add_retire_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue0 && !s0_mul) |-> ##2 retire[0]);
    // R6
    mul_retire_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue1 && s1_mul) |-> ##3 retire[3]);
    // R6
    retire_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire[1] |-> $past(issue0 && s0_mul, 3));
    // R8
    pair_waw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid && s1_valid && s1_dst == s0_dst) |-> !issue1);
    // R8
    pair_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_valid && s1_valid && s1_srca == s0_dst) |-> !issue1);
endmodule

bind dis_issue_sb dis_sb_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ooo_en   (ooo_en),
    .s0_valid (s0_valid),
    .s0_dst   (s0_dst),
    .s0_mul   (s0_mul),
    .s1_valid (s1_valid),
    .s1_dst   (s1_dst),
    .s1_srca  (s1_srca),
    .s1_mul   (s1_mul),
    .issue0   (issue0),
    .issue1   (issue1),
    .retire   (retire)
);

// File: tb/sim_dis_issue_sb.sv
// Cycle-exact behavioural reference for dis_issue_sb: an instruction queue
// as the upstream window, integer counts per register, an in-flight list.
module sim_dis_issue_sb;
    import dis_pkg::*;
    localparam int CLK_PER = 10;
    localparam int WDOG    = 150000;

    typedef struct { int d; int a; int b; bit m; } op_t;
    typedef struct { int d; int a; int b; int lane; int rem; } fl_t;

    logic clk = 0, rst_n = 0, ooo_en = 0;
    logic s0_valid = 0, s0_mul = 0, s1_valid = 0, s1_mul = 0;
    logic [REG_W-1:0] s0_dst = 0, s0_srca = 0, s0_srcb = 0;
    logic [REG_W-1:0] s1_dst = 0, s1_srca = 0, s1_srcb = 0;
    logic issue0, issue1;
    logic [NUM_LANES-1:0] retire;

    op_t prog[$];
    fl_t fl[$];
    int  rdc[NUM_REGS];
    int  wrc[NUM_REGS];
    bit  blk0 = 0;
    int  n_vec = 0, n_bad = 0, cyc = 0;
    bit  done = 0;

    always #(CLK_PER/2) clk = ~clk;

    dis_issue_sb u0 (
        .clk(clk), .rst_n(rst_n), .ooo_en(ooo_en),
        .s0_valid(s0_valid), .s0_dst(s0_dst), .s0_srca(s0_srca), .s0_srcb(s0_srcb), .s0_mul(s0_mul),
        .s1_valid(s1_valid), .s1_dst(s1_dst), .s1_srca(s1_srca), .s1_srcb(s1_srcb), .s1_mul(s1_mul),
        .issue0(issue0), .issue1(issue1), .retire(retire)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !done) begin
            n_bad++;
            $display("FAIL watchdog R2: cycles %0d expected below %0d", cyc, WDOG);
            finish_run();
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at t=%0t: actual %0d expected %0d", tag, what, $time, act, exp);
        end
    endtask

    // hazard tag against the model scoreboard; empty string means none
    function automatic string hz(op_t o);
        if (wrc[o.a] > 0 || wrc[o.b] > 0) return "R3";
        if (rdc[o.d] > 0) return "R4";
        if (wrc[o.d] > 0) return "R5";
        return "";
    endfunction

    function automatic bit pair(op_t o0, op_t o1);
        return o1.a == o0.d || o1.b == o0.d || o1.d == o0.a || o1.d == o0.b || o1.d == o0.d;
    endfunction

    // one cycle: drive window, compare, advance the model
    task automatic step(bit bubble);
        bit v0, v1, e0, e1;
        string t0, t1, h0, h1;
        op_t o0, o1;
        int eret;
        @(negedge clk);
        v0 = !bubble && prog.size() > 0;
        v1 = !bubble && prog.size() > 1;
        o0 = v0 ? prog[0] : '{d: $urandom % NUM_REGS, a: $urandom % NUM_REGS, b: $urandom % NUM_REGS, m: 1'($urandom)};
        o1 = v1 ? prog[1] : '{d: $urandom % NUM_REGS, a: $urandom % NUM_REGS, b: $urandom % NUM_REGS, m: 1'($urandom)};
        s0_valid = v0; s0_dst = REG_W'(o0.d); s0_srca = REG_W'(o0.a); s0_srcb = REG_W'(o0.b); s0_mul = o0.m;
        s1_valid = v1; s1_dst = REG_W'(o1.d); s1_srca = REG_W'(o1.a); s1_srcb = REG_W'(o1.b); s1_mul = o1.m;
        #1;
        // expected slot 0 (R12 for invalid, R7 when a stall just cleared)
        h0 = hz(o0);
        if (!v0) begin e0 = 0; t0 = "R12"; end
        else if (h0 != "") begin e0 = 0; t0 = h0; end
        else begin e0 = 1; t0 = blk0 ? "R7" : "R2"; end
        // expected slot 1
        h1 = hz(o1);
        if (!v1) begin e1 = 0; t1 = "R12"; end
        else if (h1 != "") begin e1 = 0; t1 = h1; end
        else if (v0 && pair(o0, o1)) begin e1 = 0; t1 = "R8"; end
        else if (!ooo_en && v0 && !e0) begin e1 = 0; t1 = "R9"; end
        else begin e1 = 1; t1 = (v0 && !e0) ? "R10" : (e0 ? "R11" : "R2"); end
        // expected retire strobes (R6)
        eret = 0;
        foreach (fl[i]) if (fl[i].rem == 0) eret |= (1 << fl[i].lane);
        chk(t0, "issue0", int'(issue0), int'(e0));
        chk(t1, "issue1", int'(issue1), int'(e1));
        chk("R6", "retire", int'(retire), eret);
        // advance: release retiring counts (R7), age the rest
        for (int i = fl.size() - 1; i >= 0; i--) begin
            if (fl[i].rem == 0) begin
                rdc[fl[i].a]--; rdc[fl[i].b]--; wrc[fl[i].d]--;
                fl.delete(i);
            end else fl[i].rem--;
        end
        if (e0) begin
            rdc[o0.a]++; rdc[o0.b]++; wrc[o0.d]++;
            fl.push_back('{d: o0.d, a: o0.a, b: o0.b, lane: int'(o0.m), rem: (o0.m ? MUL_LAT : ADD_LAT) - 1});
        end
        if (e1) begin
            rdc[o1.a]++; rdc[o1.b]++; wrc[o1.d]++;
            fl.push_back('{d: o1.d, a: o1.a, b: o1.b, lane: 2 + int'(o1.m), rem: (o1.m ? MUL_LAT : ADD_LAT) - 1});
        end
        if (v0) blk0 = !e0;
        if (e1) prog.delete(1);
        if (e0) prog.delete(0);
        if (e0) blk0 = 0;
    endtask

    task automatic run_prog(int bubble_pct);
        int guard = 0;
        while ((prog.size() > 0 || fl.size() > 0) && guard < 20000) begin
            step(($urandom % 100) < bubble_pct);
            guard++;
        end
        for (int i = 0; i < 3; i++) step(1);
    endtask

    task automatic push(int d, int a, int b, bit m);
        prog.push_back('{d: d, a: a, b: b, m: m});
    endtask

    task automatic slide_prog();
        push(3, 0, 1, 1); push(4, 0, 2, 0); push(5, 0, 1, 0); push(6, 1, 4, 0);
        push(7, 1, 2, 1); push(1, 0, 2, 0); push(3, 3, 1, 1); push(1, 4, 4, 0);
    endtask

    initial begin
        foreach (rdc[i]) begin rdc[i] = 0; wrc[i] = 0; end
        // R1: reset holds retire low
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk("R1", "retire in reset", int'(retire), 0);
        end
        @(negedge clk); rst_n = 1;
        #1; chk("R1", "retire after reset", int'(retire), 0);
        // R1 R2: first instruction issues at once
        push(2, 0, 1, 0);
        run_prog(0);
        // R7: dependent add behind an add producer, exact release cycle
        push(2, 0, 1, 0); push(5, 2, 2, 0);
        run_prog(0);
        // R11: two independent instructions together, then R6 same-slot retire mix
        push(1, 0, 0, 1); push(2, 3, 3, 0); push(4, 5, 5, 0); push(6, 7, 7, 1);
        run_prog(0);
        // R9 then R10: dependent pair order example, each mode
        ooo_en = 0; slide_prog(); run_prog(0);
        ooo_en = 1; slide_prog(); run_prog(0);
        // R3 R4 R5 R8 R12: dense random streams with bubbles, both modes
        for (int mode = 0; mode < 2; mode++) begin
            ooo_en = 1'(mode);
            for (int n = 0; n < 600; n++)
                push($urandom % NUM_REGS, $urandom % NUM_REGS, $urandom % NUM_REGS, 1'($urandom));
            run_prog(12);
        end
        finish_run();
    end
endmodule